// File: doc/BRIEF.md
# Stream Congestion Flow-Control Generator

This block sits beside the shared receive buffer pool of a fabric endpoint or switch. It turns occupancy readings into stop and restart commands addressed to individual traffic streams. Each command names the originating source device, the 16-bit stream number and the 8-bit traffic class of the stream. Flow control therefore acts on single end-to-end flows rather than pausing a whole link.

A small table holds the streams being watched. Each slot carries a valid flag, the three identifiers and a private "halted" flag. When occupancy reaches the upper watermark, the block halts the streams one at a time, lowest class first. This starts before the pool is exhausted. When occupancy falls to the lower watermark, only halted streams are released, highest class first. Between the two watermarks nothing is sent, so a stream cannot flap between states. The upper watermark must be strictly greater than the lower one.

Commands leave through a single registered valid/ready port, at most one per cycle. A slot's halted flag changes only when its command is accepted.

Top module: `stream_fc_gen`

## Requirements
- R1: After reset, msg_valid is low and stays low while no stream slot is valid.
- R2: While the latched occupancy is at or above HI_MARK, every valid slot that is not halted receives exactly one stop command (msg_stop = 1); a halted slot is never sent a second stop.
- R3: Stop commands are issued in ascending order of traffic class; among equal classes the lower slot index goes first.
- R4: While the latched occupancy lies strictly between LO_MARK and HI_MARK, no command is raised and every halted flag keeps its value, including for slots registered during that time.
- R5: While the latched occupancy is at or below LO_MARK, restart commands (msg_stop = 0) go only to valid slots that are halted, one command each.
- R6: Restart commands are issued in descending order of traffic class; among equal classes the lower slot index goes first.
- R7: Once msg_valid is high, it and the whole payload stay unchanged until a cycle with msg_ready high; the addressed slot's halted flag takes the new value at that accepting edge.
- R8: msg_src, msg_stream and msg_class carry the source ID, stream ID and class that the addressed slot held when the command was raised; msg_stop is 1 for stop and 0 for restart.
- R9: A registry write replaces a slot's fields and clears its halted flag; a slot written with reg_active = 0 receives no command. If a write hits the slot whose command is pending, the pending payload is unchanged, and the command's acceptance does not mark the newly written stream. This holds even when the write and the acceptance fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_valid | input | 1 | Load a new occupancy reading |
| occ_value | input | OCC_W | Buffer pool occupancy |
| reg_wr | input | 1 | Write one stream slot |
| reg_idx | input | IDX_W | Slot index to write |
| reg_active | input | 1 | Slot holds a live stream |
| reg_src | input | 16 | Source device ID of the stream |
| reg_stream | input | 16 | Stream ID |
| reg_class | input | 8 | Traffic class (0 lowest priority) |
| msg_valid | output | 1 | Command pending |
| msg_ready | input | 1 | Consumer accepts the command |
| msg_stop | output | 1 | 1 = stop, 0 = restart |
| msg_src | output | 16 | Target source ID |
| msg_stream | output | 16 | Target stream ID |
| msg_class | output | 8 | Target traffic class |

## Verification
Two events can land on the same slot in one cycle: a registry write that rewrites the slot, and the acceptance of the command already pending for that slot. The bench provokes both orders. It holds msg_ready low on a pending stop, then either rewrites the slot one cycle before accepting or drives the write and msg_ready together. It judges the outcome at the ports. The old payload must go out unchanged, and a fresh stop naming the new stream must follow, which shows that the new stream was never marked halted. A later restart phase then releases exactly that stream.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int CLS_W = 8;
  localparam int SRC_W = 16;
  localparam int SID_W = 16;

  typedef enum logic [1:0] {
    ZONE_HOLD    = 2'd0,
    ZONE_STOP    = 2'd1,
    ZONE_RESTART = 2'd2
  } zone_e;

  typedef struct packed {
    logic             active;
    logic             stopped;
    logic [CLS_W-1:0] cls;
    logic [SRC_W-1:0] src;
    logic [SID_W-1:0] sid;
  } sentry_t;

  // Occupancy to action zone; the band between the marks is the hysteresis gap.
  function automatic zone_e zone_of(input int unsigned occ, input int unsigned hi,
                                    input int unsigned lo);
    if (occ >= hi) return ZONE_STOP;
    if (occ <= lo) return ZONE_RESTART;
    return ZONE_HOLD;
  endfunction

  // A slot may be addressed in this zone.
  function automatic logic eligible(input zone_e z, input sentry_t e);
    case (z)
      ZONE_STOP:    return e.active && !e.stopped;
      ZONE_RESTART: return e.active && e.stopped;
      default:      return 1'b0;
    endcase
  endfunction

  // Class a strictly beats class b: low first when halting, high first when releasing.
  function automatic logic outranks(input zone_e z, input logic [CLS_W-1:0] a,
                                    input logic [CLS_W-1:0] b);
    return (z == ZONE_STOP) ? (a < b) : (a > b);
  endfunction
endpackage

// File: rtl/fcg_level.sv
module fcg_level import fcg_pkg::*; #(
  parameter int          OCC_W   = 10,
  parameter int unsigned HI_MARK = 768,
  parameter int unsigned LO_MARK = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             occ_valid,
  input  logic [OCC_W-1:0] occ_value,
  output zone_e            zone
);
  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         occ_q <= '0;
    else if (occ_valid) occ_q <= occ_value;
  end

  assign zone = zone_of(32'(occ_q), HI_MARK, LO_MARK);
endmodule

// File: rtl/fcg_table.sv
module fcg_table import fcg_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  sentry_t          wr_ent,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             mark_stop,
  output sentry_t          ents [N],
  output logic [N-1:0]     active_vec,
  output logic [N-1:0]     stopped_vec
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    sentry_t ent_q;

    // A registry write outranks a same-cycle mark on the same slot.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ent_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      ent_q <= wr_ent;
      else if (mark_en && mark_idx == IDX_W'(g))  ent_q.stopped <= mark_stop;
    end

    assign ents[g]        = ent_q;
    assign active_vec[g]  = ent_q.active;
    assign stopped_vec[g] = ent_q.stopped;
  end
endmodule

// File: rtl/fcg_pick.sv
module fcg_pick import fcg_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  zone_e            zone,
  input  sentry_t          ents [N],
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [CLS_W-1:0] best_cls;

  // Strict comparison keeps the lowest index among equal classes.
  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_cls = '0;
    for (int i = 0; i < N; i++) begin
      if (eligible(zone, ents[i]) && (!found || outranks(zone, ents[i].cls, best_cls))) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        best_cls = ents[i].cls;
      end
    end
  end
endmodule

// File: rtl/stream_fc_gen.sv
module stream_fc_gen import fcg_pkg::*; #(
  parameter int          N_STREAMS = 8,
  parameter int          OCC_W     = 10,
  parameter int unsigned HI_MARK   = 768,
  parameter int unsigned LO_MARK   = 256,
  localparam int         IDX_W     = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             occ_valid,
  input  logic [OCC_W-1:0] occ_value,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_active,
  input  logic [SRC_W-1:0] reg_src,
  input  logic [SID_W-1:0] reg_stream,
  input  logic [CLS_W-1:0] reg_class,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic             msg_stop,
  output logic [SRC_W-1:0] msg_src,
  output logic [SID_W-1:0] msg_stream,
  output logic [CLS_W-1:0] msg_class
);
  zone_e            zone;
  sentry_t          ents [N_STREAMS];
  sentry_t          wr_ent;
  logic [N_STREAMS-1:0] active_vec, stopped_vec;
  logic             cand_found;
  logic [IDX_W-1:0] cand_idx;
  logic [IDX_W-1:0] held_idx;
  logic             held_ok;

  // Named events, visible to the bound checker.
  logic evt_fire, evt_load, evt_mark, wr_hits_held;
  assign evt_fire     = msg_valid && msg_ready;
  assign evt_load     = !msg_valid && cand_found;
  assign wr_hits_held = reg_wr && (reg_idx == held_idx);
  assign evt_mark     = evt_fire && held_ok && !wr_hits_held;

  assign wr_ent = '{active: reg_active, stopped: 1'b0, cls: reg_class,
                    src: reg_src, sid: reg_stream};

  fcg_level #(.OCC_W(OCC_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_level (
    .clk(clk), .rst_n(rst_n), .occ_valid(occ_valid), .occ_value(occ_value), .zone(zone)
  );

  fcg_table #(.N(N_STREAMS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_idx(reg_idx), .wr_ent(wr_ent),
    .mark_en(evt_mark), .mark_idx(held_idx), .mark_stop(msg_stop),
    .ents(ents), .active_vec(active_vec), .stopped_vec(stopped_vec)
  );

  fcg_pick #(.N(N_STREAMS), .IDX_W(IDX_W)) u_pick (
    .zone(zone), .ents(ents), .found(cand_found), .idx(cand_idx)
  );

  // Output register: one command in flight; the slot is marked on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_stop   <= 1'b0;
      msg_src    <= '0;
      msg_stream <= '0;
      msg_class  <= '0;
      held_idx   <= '0;
      held_ok    <= 1'b0;
    end else begin
      if (evt_fire) begin
        msg_valid <= 1'b0;
      end else if (evt_load) begin
        msg_valid  <= 1'b1;
        msg_stop   <= (zone == ZONE_STOP);
        msg_src    <= ents[cand_idx].src;
        msg_stream <= ents[cand_idx].sid;
        msg_class  <= ents[cand_idx].cls;
        held_idx   <= cand_idx;
        held_ok    <= !(reg_wr && reg_idx == cand_idx);
      end
      if (msg_valid && wr_hits_held) held_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker import fcg_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic             msg_stop,
  input logic [SRC_W-1:0] msg_src,
  input logic [SID_W-1:0] msg_stream,
  input logic [CLS_W-1:0] msg_class,
  input zone_e            zone,
  input logic             evt_load,
  input logic             evt_mark,
  input logic [IDX_W-1:0] cand_idx,
  input logic [IDX_W-1:0] held_idx,
  input logic [N-1:0]     active_vec,
  input logic [N-1:0]     stopped_vec
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !msg_valid);

  assert_stop_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load && zone == ZONE_STOP |-> active_vec[cand_idx] && !stopped_vec[cand_idx]);

  assert_band_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load |-> zone != ZONE_HOLD);

  assert_restart_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load && zone == ZONE_RESTART |-> stopped_vec[cand_idx]);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid &&
      $stable({msg_stop, msg_src, msg_stream, msg_class}));

  assert_mark_applied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mark |=> stopped_vec[$past(held_idx)] == $past(msg_stop));
endmodule

bind stream_fc_gen fcg_checker #(.N(N_STREAMS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_stop(msg_stop), .msg_src(msg_src), .msg_stream(msg_stream), .msg_class(msg_class),
  .zone(zone), .evt_load(evt_load), .evt_mark(evt_mark), .cand_idx(cand_idx),
  .held_idx(held_idx), .active_vec(active_vec), .stopped_vec(stopped_vec)
);

// File: tb/tb_stream_fc_gen.sv
module tb_stream_fc_gen;
  localparam int N  = 8;
  localparam int OW = 10;
  localparam int HI = 768;
  localparam int LO = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic occ_valid = 1'b0;
  logic [OW-1:0] occ_value = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_idx = '0;
  logic reg_active = 1'b0;
  logic [15:0] reg_src = '0, reg_stream = '0;
  logic [7:0] reg_class = '0;
  logic msg_valid, msg_stop, msg_ready = 1'b0;
  logic [15:0] msg_src, msg_stream;
  logic [7:0] msg_class;

  always #4 clk = ~clk;  // 125 MHz

  stream_fc_gen #(.N_STREAMS(N), .OCC_W(OW), .HI_MARK(HI), .LO_MARK(LO)) dut (
    .clk(clk), .rst_n(rst_n), .occ_valid(occ_valid), .occ_value(occ_value),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_active(reg_active), .reg_src(reg_src),
    .reg_stream(reg_stream), .reg_class(reg_class), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_stop(msg_stop), .msg_src(msg_src),
    .msg_stream(msg_stream), .msg_class(msg_class)
  );

  int checks = 0, failures = 0;
  int n_stop = 0, n_rest = 0;
  bit finished = 0;
  string tag = "R1";

  // Reference model of the slot table.
  bit        m_act [N];
  bit        m_stp [N];
  bit [7:0]  m_cls [N];
  bit [15:0] m_src [N];
  bit [15:0] m_sid [N];
  int        m_occ = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // 1 = halting, 2 = releasing, 0 = silent band
  function automatic int mdl_zone();
    if (m_occ >= HI) return 1;
    if (m_occ <= LO) return 2;
    return 0;
  endfunction

  // Two passes: find the extreme class, then the first slot carrying it.
  function automatic int mdl_pick();
    int z = mdl_zone();
    int target = -1;
    if (z == 0) return -1;
    for (int i = 0; i < N; i++) begin
      if (m_act[i] && (m_stp[i] == (z == 2))) begin
        if (target < 0) target = m_cls[i];
        else if (z == 1 && m_cls[i] < target) target = m_cls[i];
        else if (z == 2 && m_cls[i] > target) target = m_cls[i];
      end
    end
    if (target < 0) return -1;
    for (int i = 0; i < N; i++)
      if (m_act[i] && (m_stp[i] == (z == 2)) && m_cls[i] == target) return i;
    return -1;
  endfunction

  // One cycle at the negedge: check any pending command, choose ready, model acceptance.
  task automatic cyc();
    int e;
    bit rdy;
    @(negedge clk);
    occ_valid = 1'b0;
    reg_wr    = 1'b0;
    if (msg_valid) begin
      e = mdl_pick();
      chk(e >= 0, tag, "command raised with nothing eligible", 1, 0);
      if (e >= 0) begin
        chk(msg_stop == (mdl_zone() == 1), tag, "msg_stop kind (R8)", msg_stop, mdl_zone() == 1);
        chk(msg_src == m_src[e], tag, "msg_src (R8)", msg_src, m_src[e]);
        chk(msg_stream == m_sid[e], tag, "msg_stream (R8)", msg_stream, m_sid[e]);
        chk(msg_class == m_cls[e], tag, "msg_class order", msg_class, m_cls[e]);
      end
    end
    rdy = ($urandom % 4) != 0;
    msg_ready = rdy;
    if (msg_valid && rdy) begin
      e = mdl_pick();
      if (e >= 0) begin
        m_stp[e] = (mdl_zone() == 1);
        if (mdl_zone() == 1) n_stop++; else n_rest++;
      end
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((mdl_pick() >= 0 || msg_valid) && guard < 400) begin
      cyc();
      guard++;
    end
    chk(guard < 400, tag, "commands drained", guard, 400);
    repeat (4) cyc();
    chk(!msg_valid, tag, "quiet after drain", msg_valid, 0);
  endtask

  task automatic set_occ(input int v);
    @(negedge clk);
    occ_valid = 1'b1;
    occ_value = OW'(v);
    m_occ = v;
    drain();
  endtask

  task automatic wr_slot(input int idx, input bit act, input int cls,
                         input int src, input int sid);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'(idx); reg_active = act;
    reg_class = 8'(cls); reg_src = 16'(src); reg_stream = 16'(sid);
    m_act[idx] = act; m_stp[idx] = 1'b0; m_cls[idx] = 8'(cls);
    m_src[idx] = 16'(src); m_sid[idx] = 16'(sid);
    drain();
  endtask

  // Registry write against a pending command on the same slot (R9).
  task automatic collide(input bit same);
    tag = "R9";
    for (int i = 0; i < N; i++) wr_slot(i, 1'b0, 0, 0, 0);
    wr_slot(0, 1'b1, 3, 'h11, 'h22);
    @(negedge clk); msg_ready = 1'b0; occ_valid = 1'b1; occ_value = OW'(HI); m_occ = HI;
    @(negedge clk); occ_valid = 1'b0;
    @(negedge clk);
    chk(msg_valid && msg_stop && msg_src == 16'h11, "R2", "stop raised for slot 0",
        msg_src, 'h11);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'd0; reg_active = 1'b1;
    reg_class = 8'd7; reg_src = 16'h33; reg_stream = 16'h44;
    if (same) msg_ready = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (!same) begin
      chk(msg_valid && msg_src == 16'h11 && msg_stream == 16'h22, "R7",
          "payload kept across slot rewrite", msg_src, 'h11);
      msg_ready = 1'b1;
      @(negedge clk);
    end
    msg_ready = 1'b0;
    @(negedge clk);
    chk(msg_valid && msg_stop && msg_src == 16'h33 && msg_class == 8'd7, "R9",
        "rewritten stream stopped afresh", msg_src, 'h33);
    chk(msg_stream == 16'h44, "R9", "rewritten stream id", msg_stream, 'h44);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    m_act[0] = 1'b1; m_stp[0] = 1'b1; m_cls[0] = 8'd7; m_src[0] = 16'h33; m_sid[0] = 16'h44;
    drain();
    n_rest = 0;
    tag = "R5";
    set_occ(LO);
    chk(n_rest == 1 && !m_stp[0], "R5", "rewritten stream released once", n_rest, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int s;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_act[i] = 0; m_stp[i] = 0; m_cls[i] = 0; m_src[i] = 0; m_sid[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!msg_valid, "R1", "msg_valid in reset", msg_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!msg_valid, "R1", "quiet with empty table", msg_valid, 0);

    // R3: ascending class, ties by index; exactly one stop each (R2).
    tag = "R3";
    wr_slot(0, 1'b1, 5, 'h100, 'h1000);
    wr_slot(1, 1'b1, 2, 'h101, 'h1001);
    wr_slot(2, 1'b1, 9, 'h102, 'h1002);
    wr_slot(3, 1'b1, 2, 'h103, 'h1003);
    wr_slot(5, 1'b0, 0, 'h105, 'h1005);
    n_stop = 0;
    set_occ(HI);
    chk(n_stop == 4, "R2", "one stop per live stream", n_stop, 4);
    tag = "R2";
    set_occ(HI + 100);
    chk(n_stop == 4, "R2", "no repeated stop", n_stop, 4);

    // R4: silent band, boundaries just inside.
    tag = "R4";
    set_occ(HI - 1);
    wr_slot(4, 1'b1, 1, 'h104, 'h1004);
    set_occ(LO + 1);
    chk(n_stop == 4 && !m_stp[4], "R4", "band leaves new stream running", n_stop, 4);

    // R5/R6: release halted streams only, highest class first.
    tag = "R6";
    n_rest = 0;
    set_occ(LO);
    chk(n_rest == 4, "R5", "restarts only halted streams", n_rest, 4);
    tag = "R9";
    n_stop = 0;
    set_occ(HI);
    chk(n_stop == 5, "R9", "inactive slot 5 never addressed", n_stop, 5);
    set_occ(0);

    // Constrained random mix.
    tag = "R7";
    for (int it = 0; it < 80; it++) begin
      s = $urandom % 3;
      if (s != 2) begin
        wr_slot($urandom % N, ($urandom % 5) != 0, $urandom % 6, $urandom % 65536,
                $urandom % 65536);
      end else begin
        case ($urandom % 5)
          0: set_occ(HI);
          1: set_occ(LO);
          2: set_occ(HI - 1);
          3: set_occ(LO + 1);
          default: set_occ($urandom % 1024);
        endcase
      end
    end
    set_occ(LO);

    collide(1'b0);
    collide(1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule